// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between the load issue stage of a 32-lane SIMD unit and the memory system. One load instruction gives it a byte address for every lane, an activity mask and an element size. From these it builds the smallest set of 128-byte line fetches that covers every byte the active lanes touch. It then presents those fetches one at a time on a valid/ready request port. Lanes that land in the same line share one fetch, whatever their order across the warp. An element that straddles a line boundary pulls in both lines.

With the same instruction, the block also judges whether the access took the fast path. That path needs every lane active, an element of four bytes or more, lane addresses that rise by exactly one element per lane, and a first address aligned to sixteen elements. The flag, the number of fetches issued and a completion pulse let the issue logic account for the cost of the access. Returned data, caching and the memory itself are handled elsewhere.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, in_ready is 1, req_valid is 0, done is 0, req_count is 0 and fast_path is 0.
- R2: Each request address is a lane's byte address with its low 7 bits cleared. Exactly one request is issued per distinct 128-byte line touched by the active lanes, so duplicate lines are merged.
- R3: Requests are ordered by the lowest lane index that touches each line. Within one lane, the lower line comes first.
- R4: An element whose last byte (address plus size minus 1) falls in the next line produces requests for both lines.
- R5: A lane whose in_mask bit is 0 adds no request. A warp with an all-zero mask completes with zero requests and still gives a done pulse.
- R6: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_addr stays unchanged in the next cycle.
- R7: req_last is 1 only with the final request of a warp. done is 1 for exactly one cycle, in the cycle after the final request is accepted. At that point req_count equals the number of requests issued for that warp and holds until the next warp is accepted.
- R8: fast_path, which is valid from the cycle after acceptance until the next acceptance, is 1 exactly when all of the following hold: all 32 lanes are active; the element size is at least 4 bytes; lane i's address equals lane 0's address plus i times the size; and lane 0's address is a multiple of 16 times the size (64, 128 or 256 bytes for 4, 8 or 16 byte elements).
- R9: in_ready is 0 from the cycle after a warp is accepted until its done pulse. An in_valid presented during that time is ignored and does not change the requests of the warp in progress.
- R10: in_size encodes the element size as 2^in_size bytes for codes 0 to 4. Codes 5 to 7 are treated as 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A warp access is presented |
| in_ready | output | 1 | Block is idle and accepts a warp |
| in_mask | input | 32 | Active lane mask, bit i for lane i |
| in_addr | input | 1024 | Lane byte addresses, lane i in bits [32*i+31:32*i] |
| in_size | input | 3 | Element size code (R10) |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 32 | Line-aligned byte address of the request |
| req_last | output | 1 | Presented request is the final one of the warp |
| done | output | 1 | One-cycle pulse at warp completion |
| req_count | output | 7 | Number of requests issued for the latest warp |
| fast_path | output | 1 | Latest warp met the fast-path rule |

## Verification
Directed warps separate the cases that a single pattern would blur. Consecutive aligned 4, 8 and 16 byte accesses must give exactly one, two and four lines with the fast flag set. A 64-byte-aligned 8-byte warp keeps the consecutive pattern but must drop the flag and spill into a third line. Reversed and descending lane orders confirm that merging and ordering follow lane index, not address. A single straddling lane, an all-inactive mask, an all-identical address and the out-of-range size codes cover the crossing, empty, merge and encoding corners. Randomized warps mix clustered, strided, scattered and consecutive addresses with random masks and random back-pressure, so duplicate detection, hold under stall and the fast-path conditions are compared against an independent model.

// File: rtl/coal_pkg.sv
package coal_pkg;

    // Largest element size supported, as log2 of bytes (16 bytes).
    localparam int MAX_SIZE_LOG = 4;

    // Map a size code to log2 of the element byte count; codes above the
    // largest supported size saturate to it.
    function automatic logic [2:0] clamp_size(input logic [2:0] code);
        return (code > 3'(MAX_SIZE_LOG)) ? 3'(MAX_SIZE_LOG) : code;
    endfunction

endpackage

// File: rtl/coal_lane_span.sv
module coal_lane_span #(
    parameter int AW       = 32,
    parameter int LINE_LOG = 7
) (
    input  logic [AW-1:0]          addr,
    input  logic [2:0]             size_log,
    output logic [AW-LINE_LOG-1:0] line_lo,
    output logic                   crosses
);
    // Address of the last byte covered by the element.
    logic [AW-1:0] tail;

    always_comb begin
        tail    = addr + ((AW'(1) << size_log) - AW'(1));
        line_lo = addr[AW-1:LINE_LOG];
        crosses = (tail[AW-1:LINE_LOG] != addr[AW-1:LINE_LOG]);
    end
endmodule

// File: rtl/coal_fast_check.sv
module coal_fast_check #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic [LANES-1:0]    mask,
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [2:0]          size_log,
    output logic                fast
);
    logic [AW-1:0]    base;
    logic [LANES-1:0] step_ok;
    logic [AW-1:0]    align_mask;
    logic             aligned;

    assign base = addr_flat[AW-1:0];

    // Every lane must sit exactly i elements above lane 0.
    for (genvar i = 0; i < LANES; i++) begin : g_step
        logic [AW-1:0] want;
        assign want       = base + (AW'(i) << size_log);
        assign step_ok[i] = (addr_flat[i*AW +: AW] == want);
    end

    always_comb begin
        align_mask = (AW'(16) << size_log) - AW'(1);
        aligned    = ((base & align_mask) == '0);
        fast       = (&mask) && (&step_ok) && (size_log >= 3'd2) && aligned;
    end
endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend[k]) idx = IW'(k);
        end
        any = |pend;
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int AW         = 32,
    parameter int LINE_BYTES = 128,
    parameter int CNT_W      = $clog2(2 * LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LANES-1:0]    in_mask,
    input  logic [LANES*AW-1:0] in_addr,
    input  logic [2:0]          in_size,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [AW-1:0]       req_addr,
    output logic                req_last,
    output logic                done,
    output logic [CNT_W-1:0]    req_count,
    output logic                fast_path
);
    import coal_pkg::*;

    localparam int LINE_LOG = $clog2(LINE_BYTES);
    localparam int LN_W     = AW - LINE_LOG;
    localparam int NENT     = 2 * LANES;      // two candidate lines per lane
    localparam int IW       = $clog2(NENT);

    typedef struct packed {
        logic                       busy;
        logic                       done;
        logic                       fast;
        logic [CNT_W-1:0]           cnt;
        logic [NENT-1:0]            pend;   // entry 2i: lane i low line, 2i+1: next line
        logic [LANES-1:0][LN_W-1:0] lines;  // low line of each lane
    } state_t;

    state_t st_q, st_d;

    // Per-lane span decode of the presented warp.
    logic [2:0]                 size_log;
    logic [LANES-1:0][LN_W-1:0] span_lo;
    logic [LANES-1:0]           span_x;
    logic                       fast_w;

    assign size_log = clamp_size(in_size);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        coal_lane_span #(.AW(AW), .LINE_LOG(LINE_LOG)) u_span (
            .addr     (in_addr[i*AW +: AW]),
            .size_log (size_log),
            .line_lo  (span_lo[i]),
            .crosses  (span_x[i])
        );
    end

    coal_fast_check #(.LANES(LANES), .AW(AW)) u_fast (
        .mask      (in_mask),
        .addr_flat (in_addr),
        .size_log  (size_log),
        .fast      (fast_w)
    );

    // Candidate line of every entry, from the stored low lines.
    logic [NENT-1:0][LN_W-1:0] ent_line;
    for (genvar k = 0; k < NENT; k++) begin : g_ent
        assign ent_line[k] = st_q.lines[k/2] + LN_W'(k % 2);
    end

    logic [IW-1:0]   sel_idx;
    logic            sel_any;
    logic [LN_W-1:0] cur_line;
    logic [NENT-1:0] match;
    logic [NENT-1:0] pend_after;

    coal_pick #(.N(NENT), .IW(IW)) u_pick (
        .pend (st_q.pend),
        .idx  (sel_idx),
        .any  (sel_any)
    );

    always_comb begin
        cur_line = ent_line[sel_idx];
        for (int k = 0; k < NENT; k++) begin
            match[k] = st_q.pend[k] && (ent_line[k] == cur_line);
        end
        pend_after = st_q.pend & ~match;
    end

    // Next-state logic.
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.fast  = fast_w;
                st_d.lines = span_lo;
                for (int i = 0; i < LANES; i++) begin
                    st_d.pend[2*i]   = in_mask[i];
                    st_d.pend[2*i+1] = in_mask[i] && span_x[i];
                end
            end
        end else if (!sel_any) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end else if (req_ready) begin
            st_d.pend = pend_after;
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            if (pend_after == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = !st_q.busy;
    assign req_valid = st_q.busy && sel_any;
    assign req_addr  = {cur_line, {LINE_LOG{1'b0}}};
    assign req_last  = req_valid && (pend_after == '0);
    assign done      = st_q.done;
    assign req_count = st_q.cnt;
    assign fast_path = st_q.fast;

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int AW    = 32,
    parameter int CNT_W = 7,
    parameter int NENT  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AW-1:0]    req_addr,
    input logic             req_last,
    input logic             done,
    input logic [CNT_W-1:0] req_count
);
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R6

    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_last) |=> (req_valid && req_addr != $past(req_addr))); // R2

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready); // R9

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_last) |=> done); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_count <= CNT_W'(NENT)); // R2
endmodule

bind warp_coalescer coal_checker #(.AW(AW), .CNT_W(CNT_W), .NENT(2 * LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_last  (req_last),
    .done      (done),
    .req_count (req_count)
);

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int CNT_W = 7;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [LANES-1:0]    in_mask = '0;
    logic [LANES*AW-1:0] in_addr = '0;
    logic [2:0]          in_size = '0;
    logic                req_valid;
    logic                req_ready = 1'b0;
    logic [AW-1:0]       req_addr;
    logic                req_last;
    logic                done;
    logic [CNT_W-1:0]    req_count;
    logic                fast_path;

    warp_coalescer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mask(in_mask), .in_addr(in_addr), .in_size(in_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_last(req_last), .done(done), .req_count(req_count), .fast_path(fast_path)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Stimulus of the current warp.
    logic [AW-1:0]    a_lane [LANES];
    logic [LANES-1:0] a_mask;
    logic [2:0]       a_size;

    // Expected and observed results.
    logic [AW-1:0] exp_line [64];
    int            exp_n;
    logic          exp_fast;
    logic [AW-1:0] got_line [64];
    logic          got_last [64];
    int            got_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int size_bytes(input logic [2:0] code);
        return (code > 3'd4) ? 16 : (1 << code);
    endfunction

    task automatic add_line(input logic [AW-1:0] ln);
        for (int j = 0; j < exp_n; j++) if (exp_line[j] == ln) return;
        exp_line[exp_n] = ln;
        exp_n++;
    endtask

    task automatic build_expected();
        int sz;
        logic [AW-1:0] lo, hi, want;
        bit cons;
        sz = size_bytes(a_size);
        exp_n = 0;
        cons = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (a_mask[i]) begin
                lo = a_lane[i] & ~32'h7F;
                hi = (a_lane[i] + AW'(sz - 1)) & ~32'h7F;
                add_line(lo);
                if (hi != lo) add_line(hi);
            end
            want = a_lane[0] + AW'(i * sz);
            if (a_lane[i] != want) cons = 1'b0;
        end
        exp_fast = (&a_mask) && (sz >= 4) && cons && ((a_lane[0] % AW'(16 * sz)) == 0);
    endtask

    task automatic run_job(input string tag, input bit poke);
        int cyc;
        bit hold_pend, prev_last, fin;
        logic [AW-1:0] hold_addr;
        bit rdy;
        build_expected();
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_mask  = a_mask;
        in_size  = a_size;
        for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = a_lane[i];
        @(negedge clk);
        in_valid = 1'b0;
        got_n = 0; cyc = 0; hold_pend = 0; prev_last = 0; fin = 0;
        while (!fin && cyc < 400) begin
            if (prev_last)
                check(done == 1'b1, "R7", {tag, " done after last"}, done, 1);
            if (done) begin
                fin = 1;
            end else begin
                if (hold_pend)
                    check(req_valid && req_addr == hold_addr, "R6", {tag, " hold"},
                          req_addr, hold_addr);
                rdy = poke && cyc == 0 ? 1'b0 : (($urandom % 4) != 0);
                req_ready = rdy;
                if (poke && cyc == 0) begin
                    check(in_ready == 1'b0, "R9", {tag, " busy in_ready"}, in_ready, 0);
                    in_valid = 1'b1;
                    in_mask  = '1;
                    in_size  = 3'd0;
                    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = $urandom;
                end else begin
                    in_valid = 1'b0;
                end
                #1;
                prev_last = 0;
                hold_pend = 0;
                if (req_valid && rdy) begin
                    if (got_n < 64) begin
                        got_line[got_n] = req_addr;
                        got_last[got_n] = req_last;
                    end
                    got_n++;
                    prev_last = req_last;
                end else if (req_valid) begin
                    hold_pend = 1;
                    hold_addr = req_addr;
                end
                @(negedge clk);
                cyc++;
            end
        end
        in_valid  = 1'b0;
        req_ready = 1'b0;
        check(fin == 1, "R7", {tag, " completion"}, fin, 1);
        check(got_n == exp_n, "R2", {tag, " request count"}, got_n, exp_n);
        for (int j = 0; j < exp_n && j < got_n; j++) begin
            check(got_line[j] == exp_line[j], "R3", {tag, " order"}, got_line[j], exp_line[j]);
            check(got_last[j] == (j == exp_n - 1), "R7", {tag, " last flag"},
                  got_last[j], (j == exp_n - 1));
        end
        check(int'(req_count) == exp_n, "R7", {tag, " req_count"}, req_count, exp_n);
        check(fast_path == exp_fast, "R8", {tag, " fast flag"}, fast_path, exp_fast);
    endtask

    task automatic fill_consec(input logic [AW-1:0] base, input logic [2:0] code);
        a_mask = '1;
        a_size = code;
        for (int i = 0; i < LANES; i++) a_lane[i] = base + AW'(i * size_bytes(code));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL R7 watchdog: actual=running expected=finished");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0A1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        check(req_valid == 1'b0, "R1", "req_valid", req_valid, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(req_count == '0, "R1", "req_count", req_count, 0);
        check(fast_path == 1'b0, "R1", "fast_path", fast_path, 0);

        // R8: aligned consecutive 4, 8, 16 byte warps
        fill_consec(32'h1000, 3'd2); run_job("R8 4B aligned", 0);
        fill_consec(32'h2000, 3'd3); run_job("R8 8B aligned", 0);
        fill_consec(32'h2040, 3'd3); run_job("R8 8B 64-aligned", 0);
        fill_consec(32'h3000, 3'd4); run_job("R8 16B aligned", 0);
        // R8, R10: 2-byte elements never take the fast path
        fill_consec(32'h3800, 3'd1); run_job("R10 2B consecutive", 0);

        // R3: reversed lane order within one line, then one line per lane descending
        a_mask = '1; a_size = 3'd2;
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h4000 + AW'((31 - i) * 4);
        run_job("R3 reversed", 0);
        a_mask = '1; a_size = 3'd0;
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h5000 + AW'((31 - i) * 128);
        run_job("R3 descending lines", 0);

        // R4: one straddling lane
        a_mask = 32'h1; a_size = 3'd2;
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h607E;
        run_job("R4 straddle", 0);

        // R5: inactive warp
        a_mask = '0; a_size = 3'd3;
        for (int i = 0; i < LANES; i++) a_lane[i] = $urandom;
        run_job("R5 empty", 0);
        // R5: only odd lanes active
        a_mask = 32'hAAAA_AAAA; a_size = 3'd0;
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h9000 + AW'(i * 128);
        run_job("R5 odd lanes", 0);

        // R2: every lane on the same address
        a_mask = '1; a_size = 3'd3;
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h8010;
        run_job("R2 duplicate", 0);

        // R10: oversize code behaves as 16 bytes
        a_mask = 32'h1; a_size = 3'd7;
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h70F8;
        run_job("R10 code7", 0);

        // R9: input offered while busy is ignored
        fill_consec(32'hA000, 3'd3); run_job("R9 busy poke", 1);

        // Random warps
        for (int n = 0; n < 220; n++) begin
            int pat;
            logic [AW-1:0] base;
            pat    = $urandom % 4;
            a_size = 3'($urandom % 8);
            a_mask = (($urandom % 3) == 0) ? '1 : LANES'($urandom);
            base   = $urandom;
            case (pat)
                0: begin
                    base = base & ~AW'((16 * size_bytes(a_size)) - 1);
                    if ($urandom % 2) base = base + AW'(size_bytes(a_size) * ($urandom % 4));
                    for (int i = 0; i < LANES; i++)
                        a_lane[i] = base + AW'(i * size_bytes(a_size));
                end
                1: for (int i = 0; i < LANES; i++) a_lane[i] = base + AW'($urandom % 1024);
                2: for (int i = 0; i < LANES; i++) a_lane[i] = $urandom;
                default: for (int i = 0; i < LANES; i++) a_lane[i] = base + AW'(i * 72);
            endcase
            run_job("R2 random", (n % 17) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule